// File: doc/BRIEF.md
# LED Driver Control Register Slave (I2C)

This block is the control-plane front end of a flash/torch LED driver. It is a two-wire serial (I2C) target that holds three read/write configuration bytes (mode command, brightness levels, indicator LED) and one read-only status byte. The master sets a register pointer, then streams bytes in or out. The pointer steps forward after every byte and wraps at the end of the map. A repeated START turns a pointer-setting write phase into a read phase.

The status byte reports fault events that the analog and protection logic raise as one-cycle pulses. Each fault bit stays set until the master reads the status byte. While any fault bit is set, an active-low attention output is pulled low. The bit that shows the flash is running follows its live input and is never latched. The target address comes from a fixed 5-bit prefix plus a 2-bit strap select. While the supply-undervoltage input is high, the target acknowledges nothing.

The decoded command and level fields drive the mode controller directly. A one-cycle strobe on every command write lets that controller reload its safety timer. SCL and SDA are oversampled on the system clock. SDA is driven only as an open-drain pull-down enable.

Top module: `lampdrv_i2c_regs`

## Requirements
- R1: The 7-bit target address is {ADDR_BASE[6:2], addr_sel_i}, with default prefix 01100. An address byte carrying any other address gets no acknowledge and causes no register change.
- R2: A write is: address with R/W=0, a pointer byte, then data bytes. Each byte is acknowledged. Only the two low bits of the pointer byte are used. Index 0 is command, 1 is dimming, 2 is auxiliary and 3 is status. The pointer advances after each data byte and wraps from 3 to 0.
- R3: A data byte sent to index 3 is acknowledged and advances the pointer, but it changes no stored state.
- R4: A read sets the pointer in a write phase, then issues a repeated START with R/W=1. Bytes are returned MSB first. A master ACK continues with the next index, with the same wrap as in R2. A master NACK ends the transfer.
- R5: While uvlo_i is high the target drives no acknowledge and performs no register write.
- R6: The status byte is laid out as follows. Bit 0 is flash running (live). Bit 1 is LED fault, bit 2 is NTC warning, bit 3 is NTC hot, bit 4 is over-temperature and bit 5 is output short; these five are latched from evt_i[0..4] in that order. Bits 7:6 read 0. attn_n_o is low while any latched bit is set.
- R7: Transmitting the status byte clears the latched bits it reported, and attn_n_o then returns high. An event in the clearing cycle stays latched. The flash-running bit is never latched.
- R8: Every write of the command register produces cmd_wr_o high for exactly one clock, in the cycle the new value appears. No other write produces it.
- R9: After reset, all registers are 0, attn_n_o is high and sda_oe_o is low.
- R10: sda_oe_o changes only while SCL is low. A START at any point restarts address reception. A STOP returns the target to idle.
- R11: The command byte, MSB to LSB, decodes to power-on, trigger-enable, torch-on, NTC-on and a 4-bit timeout code. The dimming byte decodes to the torch level in bits 7:4 and the flash level in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| addr_sel_i | input | 2 | Strap select for the low address bits |
| uvlo_i | input | 1 | Supply undervoltage, suppresses acknowledges |
| evt_i | input | 5 | Fault event pulses (LED, NTC warn, NTC hot, over-temp, short) |
| flash_run_i | input | 1 | Live flash-running state |
| pwr_on_o | output | 1 | Command: power-on |
| trig_en_o | output | 1 | Command: trigger enable |
| torch_on_o | output | 1 | Command: torch on |
| ntc_on_o | output | 1 | Command: NTC monitor on |
| tmo_code_o | output | 4 | Command: flash timeout code |
| torch_lvl_o | output | 4 | Torch brightness code |
| flash_lvl_o | output | 4 | Flash brightness code |
| aux_o | output | 8 | Indicator LED register |
| cmd_wr_o | output | 1 | One-cycle strobe on command write |
| attn_n_o | output | 1 | Attention, active low (open-drain level) |

## Verification
The bench builds the block with a two-stage line synchronizer and the default 01100 address prefix. It drives SCL at one quarter bit every five clocks, so every synchronizer and edge-detect delay fits inside a half bit. The bench steps addr_sel_i through all four values and addresses both the matching target and a neighbouring one. This covers acknowledge and non-acknowledge for each strap. Random pointers and burst lengths up to five bytes carry writes across the 3-to-0 wrap and through the ignored status index. Directed cases cover undervoltage, an aborted byte followed by a fresh START, and a status read that clears faults while the live flash bit stays visible.

// File: rtl/lampdrv_pkg.sv
package lampdrv_pkg;
  localparam int BYTE_W  = 8;
  localparam int NUM_REG = 4;
  localparam int PTR_W   = $clog2(NUM_REG);
  localparam int NUM_RW  = NUM_REG - 1;
  localparam int NUM_EVT = 5;
  localparam int CNT_W   = $clog2(BYTE_W + 1);

  localparam logic [PTR_W-1:0] IDX_CMD  = PTR_W'(0);
  localparam logic [PTR_W-1:0] IDX_DIM  = PTR_W'(1);
  localparam logic [PTR_W-1:0] IDX_AUX  = PTR_W'(2);
  localparam logic [PTR_W-1:0] IDX_STAT = PTR_W'(3);

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_ACK,
    S_PTR,
    S_PTR_ACK,
    S_WDAT,
    S_WDAT_ACK,
    S_RDAT,
    S_RACK
  } eng_state_e;
endpackage

// File: rtl/lampdrv_line_sync.sv
module lampdrv_line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '1;
        else        stg[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '1;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= stg[STAGES-1];
  end

  assign lvl  = stg[STAGES-1];
  assign rise = stg[STAGES-1] & ~prev_q;
  assign fall = ~stg[STAGES-1] & prev_q;
endmodule

// File: rtl/lampdrv_i2c_engine.sv
module lampdrv_i2c_engine
  import lampdrv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl,
  input  logic              sda,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic              uvlo,
  input  logic [6:0]        dev_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [PTR_W-1:0]  ptr,
  output logic              rd_req,
  output logic              wr_stb,
  output logic [PTR_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe,
  output logic              ack_go
);
  eng_state_e        state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic              rw_q, rw_n;
  logic              mack_q, mack_n;
  logic [PTR_W-1:0]  ptr_q, ptr_n;
  logic              oe_q, oe_n;
  logic              wstb_q, wstb_n;
  logic [PTR_W-1:0]  widx_q, widx_n;
  logic [BYTE_W-1:0] wdat_q, wdat_n;
  logic              start_det, stop_det, byte_end;

  assign start_det = sda_fall & scl;
  assign stop_det  = sda_rise & scl;
  assign byte_end  = scl_fall & (cnt_q == CNT_W'(BYTE_W));

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    rw_n    = rw_q;
    mack_n  = mack_q;
    ptr_n   = ptr_q;
    oe_n    = oe_q;
    wstb_n  = 1'b0;
    widx_n  = widx_q;
    wdat_n  = wdat_q;
    rd_req  = 1'b0;
    ack_go  = 1'b0;
    if (start_det) begin
      state_n = S_ADDR;
      cnt_n   = '0;
      oe_n    = 1'b0;
    end else if (stop_det) begin
      state_n = S_IDLE;
      oe_n    = 1'b0;
    end else begin
      unique case (state_q)
        S_ADDR, S_PTR, S_WDAT: begin
          if (scl_rise) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda};
            cnt_n = cnt_q + CNT_W'(1);
          end else if (byte_end) begin
            cnt_n = '0;
            if (uvlo) begin
              state_n = S_IDLE;
            end else if (state_q == S_ADDR) begin
              if (sh_q[BYTE_W-1:1] == dev_addr) begin
                state_n = S_ADDR_ACK;
                rw_n    = sh_q[0];
                oe_n    = 1'b1;
                ack_go  = 1'b1;
              end else begin
                state_n = S_IDLE;
              end
            end else if (state_q == S_PTR) begin
              state_n = S_PTR_ACK;
              ptr_n   = sh_q[PTR_W-1:0];
              oe_n    = 1'b1;
              ack_go  = 1'b1;
            end else begin
              state_n = S_WDAT_ACK;
              wstb_n  = 1'b1;
              widx_n  = ptr_q;
              wdat_n  = sh_q;
              ptr_n   = ptr_q + PTR_W'(1);
              oe_n    = 1'b1;
              ack_go  = 1'b1;
            end
          end
        end
        S_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (rw_q) begin
              state_n = S_RDAT;
              rd_req  = 1'b1;
              sh_n    = rd_data;
              oe_n    = ~rd_data[BYTE_W-1];
              ptr_n   = ptr_q + PTR_W'(1);
            end else begin
              state_n = S_PTR;
              oe_n    = 1'b0;
            end
          end
        end
        S_PTR_ACK, S_WDAT_ACK: begin
          if (scl_fall) begin
            state_n = S_WDAT;
            cnt_n   = '0;
            oe_n    = 1'b0;
          end
        end
        S_RDAT: begin
          if (scl_rise) begin
            cnt_n = cnt_q + CNT_W'(1);
          end else if (byte_end) begin
            state_n = S_RACK;
            oe_n    = 1'b0;
          end else if (scl_fall) begin
            sh_n = {sh_q[BYTE_W-2:0], 1'b0};
            oe_n = ~sh_q[BYTE_W-2];
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            mack_n = ~sda;
          end else if (scl_fall) begin
            if (mack_q) begin
              state_n = S_RDAT;
              cnt_n   = '0;
              rd_req  = 1'b1;
              sh_n    = rd_data;
              oe_n    = ~rd_data[BYTE_W-1];
              ptr_n   = ptr_q + PTR_W'(1);
            end else begin
              state_n = S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      ptr_q   <= '0;
      oe_q    <= 1'b0;
      wstb_q  <= 1'b0;
      widx_q  <= '0;
      wdat_q  <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      rw_q    <= rw_n;
      mack_q  <= mack_n;
      ptr_q   <= ptr_n;
      oe_q    <= oe_n;
      wstb_q  <= wstb_n;
      widx_q  <= widx_n;
      wdat_q  <= wdat_n;
    end
  end

  assign ptr     = ptr_q;
  assign sda_oe  = oe_q;
  assign wr_stb  = wstb_q;
  assign wr_idx  = widx_q;
  assign wr_data = wdat_q;
endmodule

// File: rtl/lampdrv_reg_bank.sv
module lampdrv_reg_bank
  import lampdrv_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic [PTR_W-1:0]   wr_idx,
  input  logic [BYTE_W-1:0]  wr_data,
  input  logic               rd_req,
  input  logic [PTR_W-1:0]   rd_idx,
  input  logic [NUM_EVT-1:0] evt,
  input  logic               flash_run,
  output logic [BYTE_W-1:0]  rd_data,
  output logic [BYTE_W-1:0]  cmd_byte,
  output logic [BYTE_W-1:0]  dim_byte,
  output logic [BYTE_W-1:0]  aux_byte,
  output logic               cmd_wr,
  output logic               attn_n
);
  localparam int PAD_W = BYTE_W - NUM_EVT - 1;

  logic [BYTE_W-1:0]  rw_q [NUM_RW];
  logic [BYTE_W-1:0]  rw_n [NUM_RW];
  logic [NUM_EVT-1:0] lat_q, lat_n;
  logic               cwr_q, cwr_n;
  logic               stat_clr;

  for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
    always_comb begin
      rw_n[g] = rw_q[g];
      if (wr_stb && (wr_idx == PTR_W'(g))) rw_n[g] = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rw_q[g] <= '0;
      else        rw_q[g] <= rw_n[g];
    end
  end

  assign stat_clr = rd_req && (rd_idx == IDX_STAT);

  always_comb begin
    lat_n = lat_q;
    if (stat_clr) lat_n = '0;
    lat_n = lat_n | evt;
    cwr_n = wr_stb && (wr_idx == IDX_CMD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      cwr_q <= 1'b0;
    end else begin
      lat_q <= lat_n;
      cwr_q <= cwr_n;
    end
  end

  always_comb begin
    unique case (rd_idx)
      IDX_CMD:  rd_data = rw_q[0];
      IDX_DIM:  rd_data = rw_q[1];
      IDX_AUX:  rd_data = rw_q[2];
      default:  rd_data = {{PAD_W{1'b0}}, lat_q, flash_run};
    endcase
  end

  assign cmd_byte = rw_q[0];
  assign dim_byte = rw_q[1];
  assign aux_byte = rw_q[2];
  assign cmd_wr   = cwr_q;
  assign attn_n   = ~(|lat_q);
endmodule

// File: rtl/lampdrv_i2c_regs.sv
module lampdrv_i2c_regs
  import lampdrv_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] ADDR_BASE   = 7'b0110000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [1:0]         addr_sel_i,
  input  logic               uvlo_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               flash_run_i,
  output logic               pwr_on_o,
  output logic               trig_en_o,
  output logic               torch_on_o,
  output logic               ntc_on_o,
  output logic [3:0]         tmo_code_o,
  output logic [3:0]         torch_lvl_o,
  output logic [3:0]         flash_lvl_o,
  output logic [7:0]         aux_o,
  output logic               cmd_wr_o,
  output logic               attn_n_o
);
  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  logic [1:0]        ln_lvl, ln_rise, ln_fall;
  logic              scl_lvl;
  logic [6:0]        dev_addr;
  logic [PTR_W-1:0]  ptr;
  logic              rd_req, wr_stb, ack_go;
  logic [PTR_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data, rd_data;
  logic [BYTE_W-1:0] cmd_byte, dim_byte, aux_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  lampdrv_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_core_n),
    .din  ({scl_i, sda_i}),
    .lvl  (ln_lvl),
    .rise (ln_rise),
    .fall (ln_fall)
  );
  assign scl_lvl  = ln_lvl[1];
  assign dev_addr = {ADDR_BASE[6:2], addr_sel_i};

  lampdrv_i2c_engine u_eng (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .scl     (ln_lvl[1]),
    .sda     (ln_lvl[0]),
    .scl_rise(ln_rise[1]),
    .scl_fall(ln_fall[1]),
    .sda_rise(ln_rise[0]),
    .sda_fall(ln_fall[0]),
    .uvlo    (uvlo_i),
    .dev_addr(dev_addr),
    .rd_data (rd_data),
    .ptr     (ptr),
    .rd_req  (rd_req),
    .wr_stb  (wr_stb),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .sda_oe  (sda_oe_o),
    .ack_go  (ack_go)
  );

  lampdrv_reg_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_stb   (wr_stb),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd_req   (rd_req),
    .rd_idx   (ptr),
    .evt      (evt_i),
    .flash_run(flash_run_i),
    .rd_data  (rd_data),
    .cmd_byte (cmd_byte),
    .dim_byte (dim_byte),
    .aux_byte (aux_byte),
    .cmd_wr   (cmd_wr_o),
    .attn_n   (attn_n_o)
  );

  assign pwr_on_o    = cmd_byte[7];
  assign trig_en_o   = cmd_byte[6];
  assign torch_on_o  = cmd_byte[5];
  assign ntc_on_o    = cmd_byte[4];
  assign tmo_code_o  = cmd_byte[3:0];
  assign torch_lvl_o = dim_byte[7:4];
  assign flash_lvl_o = dim_byte[3:0];
  assign aux_o       = aux_byte;
endmodule

// File: rtl/lampdrv_i2c_regs_chk.sv
module lampdrv_i2c_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cmd_byte,
  input logic       cmd_wr,
  input logic [4:0] evt,
  input logic       attn_n,
  input logic       rd_req,
  input logic [1:0] rd_idx,
  input logic       ack_go,
  input logic       uvlo,
  input logic       sda_oe,
  input logic       scl_lvl
);
  // R8
  cmd_strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> !cmd_wr);

  // R8
  cmd_change_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_byte != $past(cmd_byte)) |-> cmd_wr);

  // R6
  attn_fall_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(attn_n) |-> $past(|evt));

  // R7
  attn_rise_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(attn_n) |-> $past(rd_req && (rd_idx == 2'd3)));

  // R5
  no_ack_uvlo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_go |-> !uvlo);

  // R10
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_lvl);
endmodule

bind lampdrv_i2c_regs lampdrv_i2c_regs_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .cmd_byte(cmd_byte),
  .cmd_wr  (cmd_wr_o),
  .evt     (evt_i),
  .attn_n  (attn_n_o),
  .rd_req  (rd_req),
  .rd_idx  (ptr),
  .ack_go  (ack_go),
  .uvlo    (uvlo_i),
  .sda_oe  (sda_oe_o),
  .scl_lvl (scl_lvl)
);

// File: tb/lampdrv_i2c_regs_tb.sv
module lampdrv_i2c_regs_tb_top;
  localparam int Q = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_m, sda_m, sda_bus, sda_oe;
  logic [1:0] addr_sel;
  logic       uvlo, flash_run;
  logic [4:0] evt;
  logic       pwr_on, trig_en, torch_on, ntc_on, cmd_wr, attn_n;
  logic [3:0] tmo, tlvl, flvl;
  logic [7:0] aux;

  int checks = 0, fails = 0, stb_cnt = 0, stb_dbl = 0, stb_exp = 0;
  logic stb_prev = 1'b0;
  logic [7:0] mdl [3];
  logic [4:0] mlat;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  always #4 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  lampdrv_i2c_regs dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .addr_sel_i(addr_sel), .uvlo_i(uvlo), .evt_i(evt), .flash_run_i(flash_run),
    .pwr_on_o(pwr_on), .trig_en_o(trig_en), .torch_on_o(torch_on), .ntc_on_o(ntc_on),
    .tmo_code_o(tmo), .torch_lvl_o(tlvl), .flash_lvl_o(flvl), .aux_o(aux),
    .cmd_wr_o(cmd_wr), .attn_n_o(attn_n)
  );

  always @(posedge clk) begin
    if (cmd_wr) stb_cnt++;
    if (cmd_wr && stb_prev) stb_dbl++;
    stb_prev <= cmd_wr;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic xbit(input logic b, output logic r);
    sda_m = b; qw(); scl_m = 1'b1; qw(); r = sda_bus; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    logic r;
    for (int i = 7; i >= 0; i--) xbit(b[i], r);
    xbit(1'b1, r);
    ack = !r;
  endtask

  task automatic rbyte(input bit mack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      xbit(1'b1, r);
      b[i] = r;
    end
    xbit(!mack, r);
  endtask

  task automatic wr_seq(input logic [6:0] a, input logic [7:0] p, input int n, output bit ok);
    bit ack;
    ok = 1'b0;
    i2c_start();
    wbyte({a, 1'b0}, ack);
    if (ack) begin
      wbyte(p, ack);
      ok = ack;
      for (int i = 0; i < n; i++) begin
        wbyte(wbuf[i], ack);
        ok = ok & ack;
      end
    end
    i2c_stop();
  endtask

  task automatic rd_seq(input logic [6:0] a, input logic [7:0] p, input int n, output bit ok);
    bit ack;
    ok = 1'b0;
    i2c_start();
    wbyte({a, 1'b0}, ack);
    if (ack) begin
      wbyte(p, ack);
      i2c_start();
      wbyte({a, 1'b1}, ack);
      ok = ack;
      if (ack) for (int i = 0; i < n; i++) rbyte(i < n - 1, rbuf[i]);
    end
    i2c_stop();
  endtask

  function automatic logic [7:0] exp_byte(input int idx);
    if (idx == 3) return {2'b00, mlat, flash_run};
    return mdl[idx];
  endfunction

  task automatic model_wr(input logic [7:0] p, input int n);
    for (int i = 0; i < n; i++) begin
      int idx;
      idx = (int'(p[1:0]) + i) % 4;
      if (idx < 3) mdl[idx] = wbuf[i];
      if (idx == 0) stb_exp++;
    end
  endtask

  task automatic read_check(input logic [6:0] a, input logic [7:0] p, input int n, input string req);
    bit ok;
    rd_seq(a, p, n, ok);
    chk(req, "read address ack", int'(ok), 1);
    for (int i = 0; i < n; i++) begin
      int idx;
      idx = (int'(p[1:0]) + i) % 4;
      chk(req, $sformatf("read byte %0d idx %0d", i, idx), int'(rbuf[i]), int'(exp_byte(idx)));
      if (idx == 3) mlat = '0;
    end
  endtask

  task automatic pulse_evt(input logic [4:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
    mlat = mlat | v;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit ok;
    logic r;
    void'($urandom(32'd7341));
    scl_m = 1'b1; sda_m = 1'b1; addr_sel = 2'd0; uvlo = 1'b0; flash_run = 1'b0; evt = '0;
    for (int i = 0; i < 3; i++) mdl[i] = '0;
    mlat = '0;
    rst_n = 1'b0;
    repeat (8) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R9 reset state
    chk("R9", "command fields", int'({pwr_on, trig_en, torch_on, ntc_on, tmo}), 0);
    chk("R9", "dim/aux", int'({tlvl, flvl, aux}), 0);
    chk("R9", "attn_n", int'(attn_n), 1);
    chk("R9", "sda_oe", int'(sda_oe), 0);

    // R2 R11 single writes and field decode
    wbuf[0] = 8'hA5; wr_seq(7'h30, 8'h00, 1, ok); model_wr(8'h00, 1);
    chk("R2", "cmd write ack", int'(ok), 1);
    chk("R11", "cmd decode pwr/trig/torch/ntc", int'({pwr_on, trig_en, torch_on, ntc_on}), 4'b1010);
    chk("R11", "cmd decode timeout", int'(tmo), 5);
    wbuf[0] = 8'h3C; wr_seq(7'h30, 8'h01, 1, ok); model_wr(8'h01, 1);
    chk("R11", "torch level", int'(tlvl), 3);
    chk("R11", "flash level", int'(flvl), 12);

    // R2 R3 burst through status index with wrap; pointer byte upper bits ignored
    wbuf[0] = 8'h5A; wbuf[1] = 8'hFF; wbuf[2] = 8'h42; wbuf[3] = 8'h81;
    wr_seq(7'h30, 8'hF6, 4, ok); model_wr(8'hF6, 4);
    chk("R3", "burst ack incl. status byte", int'(ok), 1);
    chk("R2", "aux after burst", int'(aux), 8'h5A);
    chk("R2", "cmd after wrap", int'({pwr_on, trig_en, torch_on, ntc_on, tmo}), 8'h42);
    chk("R2", "dim after wrap", int'({tlvl, flvl}), 8'h81);
    read_check(7'h30, 8'h03, 1, "R3");

    // R4 multi read with wrap, NACK end, then fresh transfer
    read_check(7'h30, 8'h01, 5, "R4");
    read_check(7'h30, 8'h02, 1, "R4");

    // R1 every strap value, matching and neighbouring address
    for (int s = 0; s < 4; s++) begin
      addr_sel = 2'(s);
      repeat (2) @(negedge clk);
      wbuf[0] = 8'(8'h10 + s);
      wr_seq({5'b01100, 2'(s)}, 8'h02, 1, ok); model_wr(8'h02, 1);
      chk("R1", $sformatf("match ack sel %0d", s), int'(ok), 1);
      chk("R1", $sformatf("aux written sel %0d", s), int'(aux), 8'h10 + s);
      wbuf[0] = 8'hEE;
      wr_seq({5'b01100, 2'(s + 1)}, 8'h02, 1, ok);
      chk("R1", $sformatf("other address nack sel %0d", s), int'(ok), 0);
      chk("R1", $sformatf("aux kept sel %0d", s), int'(aux), 8'h10 + s);
    end
    wr_seq(7'h50, 8'h02, 1, ok);
    chk("R1", "foreign prefix nack", int'(ok), 0);
    addr_sel = 2'd0;

    // R5 undervoltage suppresses acknowledge and write
    uvlo = 1'b1;
    wbuf[0] = 8'h99; wr_seq(7'h30, 8'h02, 1, ok);
    chk("R5", "nack under uvlo", int'(ok), 0);
    chk("R5", "aux unchanged under uvlo", int'(aux), int'(mdl[2]));
    uvlo = 1'b0;

    // R6 R7 status latching and clear on read
    flash_run = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7", "live flash bit leaves attn high", int'(attn_n), 1);
    pulse_evt(5'b01001);
    chk("R6", "attn low after faults", int'(attn_n), 0);
    read_check(7'h30, 8'h03, 1, "R6");
    chk("R7", "attn released after status read", int'(attn_n), 1);
    read_check(7'h30, 8'h03, 1, "R7");
    flash_run = 1'b0;
    pulse_evt(5'b10110);
    chk("R6", "attn low second pattern", int'(attn_n), 0);
    read_check(7'h30, 8'h02, 2, "R7");
    chk("R7", "attn high after burst read", int'(attn_n), 1);

    // R10 START in mid-byte restarts address reception
    i2c_start();
    wbyte(8'h60, ok);
    xbit(1'b1, r); xbit(1'b0, r); xbit(1'b1, r);
    wbuf[0] = 8'h77; wr_seq(7'h30, 8'h02, 1, ok); model_wr(8'h02, 1);
    chk("R10", "restart write ack", int'(ok), 1);
    chk("R10", "aux after restart", int'(aux), 8'h77);

    // random mix, R1 R2 R4
    for (int it = 0; it < 18; it++) begin
      int s, n;
      bit bad;
      logic [7:0] p;
      s = $urandom_range(0, 3);
      bad = ($urandom_range(0, 4) == 0);
      n = $urandom_range(1, 5);
      p = 8'($urandom);
      addr_sel = 2'(s);
      repeat (2) @(negedge clk);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      wr_seq(bad ? {5'b01100, 2'(s + 2)} : {5'b01100, 2'(s)}, p, n, ok);
      chk(bad ? "R1" : "R2", "random write ack", int'(ok), int'(!bad));
      if (!bad) model_wr(p, n);
      read_check({5'b01100, 2'(s)}, 8'h00, 3, "R4");
    end

    // R8 strobe count and width
    chk("R8", "command strobe count", stb_cnt, stb_exp);
    chk("R8", "strobe wider than one cycle", stb_dbl, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule